// File: doc/BRIEF.md
# Single-Wire ASK Transmit Protocol Controller

This block sequences a low-frequency wake-up transmitter from one open-drain control wire owned by a host. In standby it does nothing until it sees the wire low. From then on the wire, after debouncing, gates the carrier driver: a debounced low turns the driver on and a debounced high turns it off. The result is 100% amplitude-shift keying that follows the host's data.

Two supervisors guard the wire. A cumulative low-time watchdog drops the block back to standby if the wire seems stuck low. The host keeps a long burst alive by inserting a short high pulse before that limit is reached. A long, unbroken high marks the end of a transmission. The block then answers on the same wire by pulling it low for one of two widths. The long pulse means clean and the short pulse means a fault was flagged. Then it returns to standby.

All times are counted in carrier ticks (`tickEn` pulses). The timing therefore scales with the antenna frequency. The default parameters match a 125 kHz carrier.

Top module: `ask_line_ctrl`

## Requirements
- R1: After reset the block is in standby (`standby`=1) with `drvEn`=0 and `linePull`=0, and it stays there while the wire is high.
- R2: In standby, a tick with `lineIn`=0 wakes the block (`standby`=0). That tick counts as the first of the DEB_TICKS consecutive low ticks after which `drvEn` goes to 1.
- R3: While active, `drvEn` falls only after DEB_TICKS consecutive high ticks. A run of fewer ticks of the opposite level leaves `drvEn` unchanged.
- R4: The block counts low ticks while active, including the waking tick. When the count reaches LOWTO_TICKS it returns to standby with the driver off and sends no reply pulse.
- R5: A high run of at least TOR_TICKS consecutive ticks clears the low-tick count. A shorter high run does not clear it.
- R6: After a stuck-low timeout the block does not wake again until it has seen at least one high tick in standby.
- R7: HIGHTO_TICKS consecutive high ticks end the transmission. `linePull` is then 1 for exactly ACK_TICKS ticks, after which the block is in standby.
- R8: If `faultIn` was 1 in any cycle while active, the reply lasts ERR_TICKS ticks instead of ACK_TICKS.
- R9: The fault memory is cleared on entering standby. `faultIn` asserted while in standby has no effect on the next reply.
- R10: While `linePull` is 1, `lineIn` is ignored: a low wire neither lengthens the reply nor wakes the block afterwards.
- R11: Cycles without `tickEn` do not advance wake-up, debouncing, timeouts or the reply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tickEn | input | 1 | One-cycle carrier tick strobe; the time base |
| lineIn | input | 1 | Synchronized wire level (1 = high) |
| faultIn | input | 1 | Fault flag from the driver diagnostics |
| drvEn | output | 1 | Carrier driver enable |
| linePull | output | 1 | Open-drain pull-down of the wire |
| standby | output | 1 | Block is in standby |

## Verification
Most wrong internal states show on `drvEn`, `standby` or `linePull` within one tick of the boundary they guard. A debounce counter that is off by one moves the `drvEn` edge by one tick. A low counter that is not cleared, or is cleared too early, moves the stuck-low drop-out by tens of ticks. A stale fault memory shows up only at the next reply, as the wrong pulse width. The bench runs a small configuration and places every check on the exact tick where a counter reaches its limit and on the tick just before it. This is so an off-by-one error fails a check.

// File: rtl/ask_line_ctrl_pkg.sv
package ask_line_ctrl_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_TX    = 2'd1,
    ST_REPLY = 2'd2
  } ctrlState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic start;      // wake tick: preset the counters
    logic count;      // active tick: advance debounce and timeouts
    logic loadAck;    // load long reply length
    logic loadErr;    // load short reply length
    logic replyStep;  // reply tick: count down
  } dpStrobe_t;

endpackage

// File: rtl/ask_line_ctrl_dp.sv
module ask_line_ctrl_dp
  import ask_line_ctrl_pkg::*;
#(
  parameter int DEB_TICKS    = 8,
  parameter int TOR_TICKS    = 4,
  parameter int LOWTO_TICKS  = 2000,
  parameter int HIGHTO_TICKS = 2000,
  parameter int ACK_TICKS    = 32,
  parameter int ERR_TICKS    = 16
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tickEn,
  input  logic      lineIn,
  input  dpStrobe_t stb,
  output logic      dbLow,
  output logic      lowHit,
  output logic      highHit,
  output logic      replyZero
);

  localparam int DEB_W = $clog2(DEB_TICKS + 1);
  localparam int LOW_W = $clog2(LOWTO_TICKS + 1);
  localparam int HI_W  = $clog2(HIGHTO_TICKS + 1);
  localparam int RPL_MAX = (ACK_TICKS > ERR_TICKS) ? ACK_TICKS : ERR_TICKS;
  localparam int RPL_W = $clog2(RPL_MAX + 1);

  logic             dbLevel;
  logic [DEB_W-1:0] runCnt;
  logic [LOW_W-1:0] lowCnt;
  logic [HI_W-1:0]  hiRun;
  logic [RPL_W-1:0] replyCnt;

  // debounced level; 1 = high (carrier off)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dbLevel <= 1'b1;
      runCnt  <= '0;
    end else if (stb.start) begin
      dbLevel <= 1'b1;
      runCnt  <= DEB_W'(1);
    end else if (stb.count) begin
      if (lineIn != dbLevel) begin
        if (runCnt == DEB_W'(DEB_TICKS - 1)) begin
          dbLevel <= lineIn;
          runCnt  <= '0;
        end else begin
          runCnt <= runCnt + DEB_W'(1);
        end
      end else begin
        runCnt <= '0;
      end
    end
  end

  // cumulative low time and consecutive high run
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lowCnt <= '0;
      hiRun  <= '0;
    end else if (stb.start) begin
      lowCnt <= LOW_W'(1);
      hiRun  <= '0;
    end else if (stb.count) begin
      if (!lineIn) begin
        lowCnt <= lowCnt + LOW_W'(1);
        hiRun  <= '0;
      end else begin
        hiRun <= hiRun + HI_W'(1);
        if (hiRun == HI_W'(TOR_TICKS - 1)) lowCnt <= '0;
      end
    end
  end

  // reply pulse length
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      replyCnt <= '0;
    end else if (stb.loadErr) begin
      replyCnt <= RPL_W'(ERR_TICKS - 1);
    end else if (stb.loadAck) begin
      replyCnt <= RPL_W'(ACK_TICKS - 1);
    end else if (stb.replyStep && replyCnt != '0) begin
      replyCnt <= replyCnt - RPL_W'(1);
    end
  end

  assign dbLow     = !dbLevel;
  assign lowHit    = !lineIn && (lowCnt == LOW_W'(LOWTO_TICKS - 1));
  assign highHit   = lineIn && (hiRun == HI_W'(HIGHTO_TICKS - 1));
  assign replyZero = (replyCnt == '0);

  // R11
  tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tickEn |=> $stable(dbLevel) && $stable(lowCnt) && $stable(hiRun));

  // R4
  low_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lowCnt <= LOW_W'(LOWTO_TICKS));

  // R7
  reply_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stb.replyStep && !replyZero && !stb.loadAck && !stb.loadErr |=> replyCnt < $past(replyCnt));

endmodule

// File: rtl/ask_line_ctrl_fsm.sv
module ask_line_ctrl_fsm
  import ask_line_ctrl_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tickEn,
  input  logic      lineIn,
  input  logic      faultIn,
  input  logic      dbLow,
  input  logic      lowHit,
  input  logic      highHit,
  input  logic      replyZero,
  output dpStrobe_t stb,
  output logic      drvEn,
  output logic      linePull,
  output logic      standby
);

  ctrlState_t state;
  logic       needHigh;
  logic       faultSeen;
  logic       wakeNow;
  logic       endNow;

  assign wakeNow = (state == ST_IDLE) && tickEn && !lineIn && !needHigh;
  assign endNow  = (state == ST_TX) && tickEn && highHit;

  always_comb begin
    stb           = '0;
    stb.start     = wakeNow;
    stb.count     = (state == ST_TX) && tickEn;
    stb.loadErr   = endNow && (faultSeen || faultIn);
    stb.loadAck   = endNow && !(faultSeen || faultIn);
    stb.replyStep = (state == ST_REPLY) && tickEn;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      needHigh  <= 1'b0;
      faultSeen <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          faultSeen <= 1'b0;
          if (tickEn && lineIn) needHigh <= 1'b0;
          if (wakeNow) state <= ST_TX;
        end
        ST_TX: begin
          if (faultIn) faultSeen <= 1'b1;
          if (tickEn && lowHit) begin
            state     <= ST_IDLE;
            needHigh  <= 1'b1;
            faultSeen <= 1'b0;
          end else if (endNow) begin
            state <= ST_REPLY;
          end
        end
        ST_REPLY: begin
          if (tickEn && replyZero) begin
            state     <= ST_IDLE;
            faultSeen <= 1'b0;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign drvEn    = (state == ST_TX) && dbLow;
  assign linePull = (state == ST_REPLY);
  assign standby  = (state == ST_IDLE);

  // R11
  state_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tickEn |=> $stable(state));

  // R6
  rewake_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    standby && needHigh && !lineIn |=> standby);

endmodule

// File: rtl/ask_line_ctrl.sv
module ask_line_ctrl
  import ask_line_ctrl_pkg::*;
#(
  parameter int DEB_TICKS    = 8,
  parameter int TOR_TICKS    = 4,
  parameter int LOWTO_TICKS  = 2000,
  parameter int HIGHTO_TICKS = 2000,
  parameter int ACK_TICKS    = 32,
  parameter int ERR_TICKS    = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tickEn,
  input  logic lineIn,
  input  logic faultIn,
  output logic drvEn,
  output logic linePull,
  output logic standby
);

  dpStrobe_t stb;
  logic      dbLow;
  logic      lowHit;
  logic      highHit;
  logic      replyZero;

  ask_line_ctrl_dp #(
    .DEB_TICKS   (DEB_TICKS),
    .TOR_TICKS   (TOR_TICKS),
    .LOWTO_TICKS (LOWTO_TICKS),
    .HIGHTO_TICKS(HIGHTO_TICKS),
    .ACK_TICKS   (ACK_TICKS),
    .ERR_TICKS   (ERR_TICKS)
  ) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .tickEn   (tickEn),
    .lineIn   (lineIn),
    .stb      (stb),
    .dbLow    (dbLow),
    .lowHit   (lowHit),
    .highHit  (highHit),
    .replyZero(replyZero)
  );

  ask_line_ctrl_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .tickEn   (tickEn),
    .lineIn   (lineIn),
    .faultIn  (faultIn),
    .dbLow    (dbLow),
    .lowHit   (lowHit),
    .highHit  (highHit),
    .replyZero(replyZero),
    .stb      (stb),
    .drvEn    (drvEn),
    .linePull (linePull),
    .standby  (standby)
  );

  // R7
  drive_pull_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(drvEn && linePull));

  // R1
  standby_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    standby |-> !drvEn && !linePull);

  // R7
  reply_after_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(linePull) |-> $past(lineIn) && $past(tickEn));

endmodule

// File: tb/ask_line_ctrl_bench.sv
module ask_line_ctrl_bench;

  localparam int CLK_PERIOD = 10;
  localparam int DEB    = 4;
  localparam int TOR    = 2;
  localparam int LOWTO  = 40;
  localparam int HIGHTO = 30;
  localparam int ACK    = 8;
  localparam int ERR    = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tickEn = 1'b1;
  logic lineIn = 1'b1;
  logic faultIn = 1'b0;
  logic drvEn, linePull, standby;

  int nChecks = 0;
  int nFail = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  ask_line_ctrl #(
    .DEB_TICKS(DEB), .TOR_TICKS(TOR), .LOWTO_TICKS(LOWTO),
    .HIGHTO_TICKS(HIGHTO), .ACK_TICKS(ACK), .ERR_TICKS(ERR)
  ) u_ask_line_ctrl (
    .clk(clk), .rst_n(rst_n), .tickEn(tickEn), .lineIn(lineIn),
    .faultIn(faultIn), .drvEn(drvEn), .linePull(linePull), .standby(standby)
  );

  task automatic check(input string req, input string what, input logic act, input logic exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic expect3(input string req, input logic s, input logic d, input logic p);
    check(req, "standby", standby, s);
    check(req, "drvEn", drvEn, d);
    check(req, "linePull", linePull, p);
  endtask

  // drive a level for n clock edges, sample 1 time unit after the last edge
  task automatic hold(input logic lvl, input int n);
    for (int i = 0; i < n; i++) begin
      lineIn = lvl;
      @(posedge clk);
      #1;
    end
  endtask

  task automatic doReset();
    rst_n = 1'b0; lineIn = 1'b1; tickEn = 1'b1; faultIn = 1'b0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    nFail++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

  initial begin
    // R1 reset state, R2 wake and debounce on
    doReset();
    expect3("R1", 1, 0, 0);
    hold(1, 5);  expect3("R1", 1, 0, 0);
    hold(0, 1);  expect3("R2", 0, 0, 0);
    hold(0, 2);  expect3("R2", 0, 0, 0);
    hold(0, 1);  expect3("R2", 0, 1, 0);
    // R3 short runs filtered, full run switches off
    hold(1, 3);  check("R3", "drvEn", drvEn, 1);
    hold(0, 1);  check("R3", "drvEn", drvEn, 1);
    hold(1, 3);  check("R3", "drvEn", drvEn, 1);
    hold(1, 1);  check("R3", "drvEn", drvEn, 0);
    hold(0, 3);  check("R3", "drvEn", drvEn, 0);
    hold(0, 1);  check("R3", "drvEn", drvEn, 1);

    // R4 stuck-low timeout, R6 no re-wake until high
    doReset();
    hold(0, 39); expect3("R4", 0, 1, 0);
    hold(0, 1);  expect3("R4", 1, 0, 0);
    hold(0, 20); check("R6", "standby", standby, 1);
    hold(1, 1);  check("R6", "standby", standby, 1);
    hold(0, 1);  check("R6", "standby", standby, 0);

    // R5 timeout reset pulse
    doReset();
    hold(0, 30);
    hold(1, TOR);
    hold(0, 30); expect3("R5", 0, 1, 0);
    hold(1, 1);
    hold(0, 9);  expect3("R5", 0, 1, 0);
    hold(0, 1);  expect3("R5", 1, 0, 0);

    // R7 end detection and acknowledge, R10 line ignored while pulling
    doReset();
    hold(0, 10); check("R7", "drvEn", drvEn, 1);
    hold(1, 4);  expect3("R7", 0, 0, 0);
    hold(1, 25); expect3("R7", 0, 0, 0);
    hold(1, 1);  expect3("R7", 0, 0, 1);
    hold(0, ACK - 1); expect3("R10", 0, 0, 1);
    hold(0, 1);  expect3("R7", 1, 0, 0);
    hold(1, 1);  expect3("R10", 1, 0, 0);

    // R8 error reply
    doReset();
    hold(0, 10);
    faultIn = 1'b1; hold(0, 1); faultIn = 1'b0;
    hold(1, HIGHTO); expect3("R8", 0, 0, 1);
    hold(1, ERR - 1); check("R8", "linePull", linePull, 1);
    hold(1, 1);  expect3("R8", 1, 0, 0);

    // R9 fault cleared in standby, fault in standby ignored
    faultIn = 1'b1; hold(1, 3); faultIn = 1'b0;
    check("R9", "standby", standby, 1);
    hold(0, 10);
    hold(1, HIGHTO); check("R9", "linePull", linePull, 1);
    hold(1, ACK - 1); check("R9", "linePull", linePull, 1);
    hold(1, 1);  expect3("R9", 1, 0, 0);

    // R11 tick gating
    doReset();
    tickEn = 1'b0;
    hold(0, 20); check("R11", "standby", standby, 1);
    tickEn = 1'b1;
    hold(0, 1);  check("R11", "standby", standby, 0);
    tickEn = 1'b0;
    hold(0, 60); expect3("R11", 0, 0, 0);
    tickEn = 1'b1;
    hold(0, 2);  check("R11", "drvEn", drvEn, 0);
    hold(0, 1);  check("R11", "drvEn", drvEn, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

endmodule